// File: doc/BRIEF.md
# Asynchronous Bus Slave Access Qualifier

This block is the device-side front end of a 32-bit asynchronous static-memory-style bus driven by a host's external memory controller. It brings the active-low select, read-enable and write-enable pins, the word address and the data bus into the local clock domain through two-flop synchronisers. An access is accepted only once the select is active and the word address has held one value long enough. The block then gives the local register file exactly one single-cycle read or write strobe, together with the captured word address and, for writes, the captured data.

Read data from the register file goes back onto the shared data bus. It is driven only while the raw select and read-enable pins are both low; at all other times the block releases the bus. When the host keeps the select low and moves to a new address, the stable condition drops and then builds up again. Each address therefore counts as its own access. Debug outputs show the synchronised select, the qualification result and the two honoured flags. An error pulse marks a window in which both enables were seen low.

Top module: `absq_front`

## Requirements
- R1: While the synchronised select is inactive (`bus_cs_n` high), `dbg_addr_stable`, `dbg_rd_ok` and `dbg_wr_ok` are 0. No strobe appears in the cycle after such a cycle.
- R2: `bus_addr` carries the word address (bus address bits 10 down to 2, bit 0 of the port being address bit 2). With each strobe, `loc_addr` shows the synchronised word address that was seen in the qualifying cycle.
- R3: `dbg_addr_stable` is 1 in a cycle only if the synchronised select is active and the synchronised address equals its previous-cycle value, and that same match also held in each of the STABLE_CYC cycles before. With the default of 1, pins held steady for 2 clock edges give no access and pins held for 3 edges give exactly one.
- R4: Each qualified window gives exactly one strobe, one clock cycle wide, in the cycle after the window's first honoured cycle, however long the window lasts.
- R5: If the address changes while the select stays low, the window ends and a new window qualifies at the new address. Each address produces its own strobe.
- R6: If write-enable and read-enable are both seen low in the honoured cycle, only `loc_wr_stb` fires. `err_conflict` pulses in that same cycle.
- R7: `bus_data` carries `loc_rdata` exactly while the raw `bus_cs_n` and `bus_oe_n` pins are both low. Otherwise the block does not drive the bus.
- R8: Every bus input passes through two flops. A change on `bus_cs_n` appears on `dbg_cs_act` after the second rising clock edge.
- R9: `dbg_cs_act` is the synchronised active select. `dbg_rd_ok` is qualified AND read-enable AND NOT write-enable. `dbg_wr_ok` is qualified AND write-enable.
- R10: With `loc_wr_stb`, `loc_wdata` shows the synchronised data-bus value from the qualifying cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Asynchronous chip select, active low |
| bus_oe_n | input | 1 | Asynchronous output (read) enable, active low |
| bus_we_n | input | 1 | Asynchronous write enable, active low |
| bus_addr | input | 9 | Word address, bus bits 10..2 |
| bus_data | inout | 32 | Shared data bus |
| loc_rd_stb | output | 1 | One-cycle local read strobe |
| loc_wr_stb | output | 1 | One-cycle local write strobe |
| loc_addr | output | 9 | Captured word address |
| loc_wdata | output | 32 | Captured write data |
| loc_rdata | input | 32 | Read data from the register file |
| err_conflict | output | 1 | Both enables low in one honoured window |
| dbg_cs_act | output | 1 | Synchronised select, active high |
| dbg_addr_stable | output | 1 | Qualification result |
| dbg_rd_ok | output | 1 | Read honoured this cycle |
| dbg_wr_ok | output | 1 | Write honoured this cycle |

## Verification
The read path and the write path can both claim the same qualified cycle. The bench provokes this by holding the select, read-enable and write-enable low together at one steady address. The case is judged correct when a single write strobe and an error pulse appear in the same cycle and no read strobe appears anywhere in that window. A behavioural reference model runs alongside and checks on every cycle that neither path wins outside this rule.

// File: rtl/absq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the access qualifier.
// Assumes the control pins are bundled as {we_n, oe_n, cs_n}.
package absq_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    localparam int CTRL_W  = 3;
    localparam int CTRL_CS = 0;
    localparam int CTRL_OE = 1;
    localparam int CTRL_WE = 2;
endpackage

// File: rtl/absq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for an asynchronous vector.
// Assumes each bit may be sampled independently; the consumers of the
// vector tolerate one cycle of skew between its bits.
module absq_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (i == 0) begin : g_first
            // First stage: sample the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d_async;
            end
        end else begin : g_next
            // Later stages: pass the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stage[i-1].q;
            end
        end
    end

    assign d_sync = g_stage[STAGES-1].q;
endmodule

// File: rtl/absq_qualify.sv
`timescale 1ns/1ps
// Address stability qualifier.
// Raises qual when the select is active and the address has matched its
// previous-cycle value on the current cycle and on STABLE_CYC prior cycles.
// Assumes synchronised inputs.
module absq_qualify #(
    parameter int ADDR_W     = 9,
    parameter int STABLE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic [ADDR_W-1:0] addr,
    output logic              qual
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(STABLE_CYC);

    logic [ADDR_W-1:0] addr_prev_q;
    logic [CNT_W-1:0]  run_q;
    logic              match;

    // Comparator: current synchronised address against last cycle's.
    always_comb begin
        match = cs_act && (addr == addr_prev_q);
        qual  = match && (run_q >= RUN_MAX);
    end

    // Track the previous address and count consecutive matching cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_prev_q <= '0;
            run_q       <= '0;
        end else begin
            addr_prev_q <= addr;
            if (!match)              run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + CNT_W'(1);
        end
    end

    // R3: a qualified cycle follows a cycle with the same address and select active.
    p_qual_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> (addr == $past(addr)) && $past(cs_act) && cs_act);
endmodule

// File: rtl/absq_strobe.sv
`timescale 1ns/1ps
// Access strobe generator.
// Turns a qualified window into one registered strobe, write winning over
// read, and captures address and data. Assumes qual drops between windows.
module absq_strobe
    import absq_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              oe_act,
    input  logic              we_act,
    input  logic              qual,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              err,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] wdata_out
);
    acc_kind_e kind;
    logic      done_q;

    // Decide which access, if any, fires this cycle.
    always_comb begin
        rd_ok = qual && oe_act && !we_act;
        wr_ok = qual && we_act;
        kind  = ACC_IDLE;
        if (!done_q) begin
            if (wr_ok)      kind = ACC_WRITE;
            else if (rd_ok) kind = ACC_READ;
        end
    end

    // Register strobes, the window's done flag and the captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stb    <= 1'b0;
            wr_stb    <= 1'b0;
            err       <= 1'b0;
            done_q    <= 1'b0;
            addr_out  <= '0;
            wdata_out <= '0;
        end else begin
            rd_stb <= (kind == ACC_READ);
            wr_stb <= (kind == ACC_WRITE);
            err    <= (kind == ACC_WRITE) && oe_act;
            done_q <= qual && (done_q || (kind != ACC_IDLE));
            if (kind != ACC_IDLE) begin
                addr_out  <= addr;
                wdata_out <= wdata;
            end
        end
    end

    // R1: an inactive select is never followed by a strobe.
    p_idle_no_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !(rd_stb || wr_stb));
    // R4: strobes are one cycle wide.
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    // R3: every strobe is preceded by a qualified cycle.
    p_stb_after_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> $past(qual));
    // R6: a conflict flag only comes with a lone write strobe.
    p_err_is_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (wr_stb && !rd_stb));
endmodule

// File: rtl/absq_front.sv
`timescale 1ns/1ps
// Asynchronous bus slave access qualifier, top level.
// Synchronises the bus pins, qualifies stable word accesses, strobes the
// local register file and returns read data on the shared bus.
// Assumes 32-bit word-aligned accesses only.
module absq_front
    import absq_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 32,
    parameter int STABLE_CYC = 1,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              loc_rd_stb,
    output logic              loc_wr_stb,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              err_conflict,
    output logic              dbg_cs_act,
    output logic              dbg_addr_stable,
    output logic              dbg_rd_ok,
    output logic              dbg_wr_ok
);
    logic [CTRL_W-1:0] ctrl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              cs_act, oe_act, we_act, qual, drive_en;

    absq_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STG), .RST_VAL({CTRL_W{1'b1}})) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n),
        .d_async({bus_we_n, bus_oe_n, bus_cs_n}), .d_sync(ctrl_s));
    absq_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STG)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d_async(bus_addr), .d_sync(addr_s));
    absq_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STG)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .d_async(bus_data), .d_sync(data_s));

    // Active-high views of the synchronised control pins.
    always_comb begin
        cs_act = ~ctrl_s[CTRL_CS];
        oe_act = ~ctrl_s[CTRL_OE];
        we_act = ~ctrl_s[CTRL_WE];
    end

    absq_qualify #(.ADDR_W(ADDR_W), .STABLE_CYC(STABLE_CYC)) u_qualify (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .addr(addr_s), .qual(qual));

    absq_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .oe_act(oe_act), .we_act(we_act),
        .qual(qual), .addr(addr_s), .wdata(data_s),
        .rd_ok(dbg_rd_ok), .wr_ok(dbg_wr_ok),
        .rd_stb(loc_rd_stb), .wr_stb(loc_wr_stb), .err(err_conflict),
        .addr_out(loc_addr), .wdata_out(loc_wdata));

    // Drive the bus straight from the raw pins so the read turns on at once.
    assign drive_en = ~bus_cs_n & ~bus_oe_n;
    assign bus_data = drive_en ? loc_rdata : {DATA_W{1'bz}};

    assign dbg_cs_act      = cs_act;
    assign dbg_addr_stable = qual;
endmodule

// File: tb/absq_front_test.sv
`timescale 1ns/1ps
module absq_front_test;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;
    localparam int STABLE = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              drv = 1'b0;
    logic [DATA_W-1:0] dat = '0;
    wire  [DATA_W-1:0] bus_data;
    assign bus_data = drv ? dat : {DATA_W{1'bz}};

    logic              loc_rd_stb, loc_wr_stb, err_conflict;
    logic              dbg_cs_act, dbg_addr_stable, dbg_rd_ok, dbg_wr_ok;
    logic [ADDR_W-1:0] loc_addr;
    logic [DATA_W-1:0] loc_wdata, loc_rdata;
    assign loc_rdata = 32'hA500_0000 | {23'd0, loc_addr};

    absq_front uut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_addr(addr), .bus_data(bus_data),
        .loc_rd_stb(loc_rd_stb), .loc_wr_stb(loc_wr_stb), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .err_conflict(err_conflict),
        .dbg_cs_act(dbg_cs_act), .dbg_addr_stable(dbg_addr_stable),
        .dbg_rd_ok(dbg_rd_ok), .dbg_wr_ok(dbg_wr_ok));

    int checks = 0, failures = 0, n_rd = 0, n_wr = 0, n_err = 0;
    bit started = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Pin snapshot taken between edges, used by the model at the next edge.
    bit sn_cs, sn_oe, sn_we; int sn_addr; logic [31:0] sn_d;
    always @(negedge clk) begin
        #1;
        sn_cs = !cs_n; sn_oe = !oe_n; sn_we = !we_n; sn_addr = addr; sn_d = bus_data;
    end

    // Behavioural reference: q1 = last sample, v = synchronised view, pv = view before.
    bit q1_cs, q1_oe, q1_we, v_cs, v_oe, v_we, pv_cs; int q1_a, v_a, pv_a;
    logic [31:0] q1_d, v_d;
    int run; bit done;
    bit c_match, c_qual, c_rdok, c_wrok, c_frd, c_fwr, c_err; int c_addr; logic [31:0] c_wd;
    bit e_rd, e_wr, e_err; int e_addr; logic [31:0] e_wd;

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            {q1_cs, q1_oe, q1_we, v_cs, v_oe, v_we, pv_cs} = '0;
            q1_a = 0; v_a = 0; pv_a = 0; q1_d = '0; v_d = '0;
            run = 0; done = 0;
            {c_match, c_qual, c_rdok, c_wrok, c_frd, c_fwr, c_err} = '0;
            e_rd = 0; e_wr = 0; e_err = 0; e_addr = 0; e_wd = '0;
        end else begin
            e_rd = c_frd; e_wr = c_fwr; e_err = c_err;
            if (c_frd || c_fwr) begin e_addr = c_addr; e_wd = c_wd; end
            run  = c_match ? ((run < STABLE) ? run + 1 : run) : 0;
            done = c_qual && (done || c_frd || c_fwr);
            pv_cs = v_cs; pv_a = v_a;
            v_cs = q1_cs; v_oe = q1_oe; v_we = q1_we; v_a = q1_a; v_d = q1_d;
            q1_cs = sn_cs; q1_oe = sn_oe; q1_we = sn_we; q1_a = sn_addr; q1_d = sn_d;
        end
        c_match = v_cs && (v_a == pv_a);
        c_qual  = c_match && (run >= STABLE);
        c_rdok  = c_qual && v_oe && !v_we;
        c_wrok  = c_qual && v_we;
        c_fwr   = c_wrok && !done;
        c_frd   = c_rdok && !done;
        c_err   = c_fwr && v_oe;
        c_addr  = v_a; c_wd = v_d;
    end

    // Per-cycle comparison against the model, between edges.
    always @(negedge clk) begin
        #1;
        if (started) begin
            check(dbg_cs_act == v_cs, "R9 dbg_cs_act", 32'(dbg_cs_act), 32'(v_cs));
            check(dbg_addr_stable == c_qual, "R3 dbg_addr_stable", 32'(dbg_addr_stable), 32'(c_qual));
            check(dbg_rd_ok == c_rdok, "R9 dbg_rd_ok", 32'(dbg_rd_ok), 32'(c_rdok));
            check(dbg_wr_ok == c_wrok, "R9 dbg_wr_ok", 32'(dbg_wr_ok), 32'(c_wrok));
            check(loc_rd_stb == e_rd, "R4 loc_rd_stb", 32'(loc_rd_stb), 32'(e_rd));
            check(loc_wr_stb == e_wr, "R4 loc_wr_stb", 32'(loc_wr_stb), 32'(e_wr));
            check(err_conflict == e_err, "R6 err_conflict", 32'(err_conflict), 32'(e_err));
            if (e_rd || e_wr)
                check(int'(loc_addr) == e_addr, "R2 loc_addr", 32'(loc_addr), 32'(e_addr));
            if (e_wr)
                check(loc_wdata == e_wd, "R10 loc_wdata", loc_wdata, e_wd);
            if (!cs_n && !oe_n)
                check(bus_data == loc_rdata, "R7 bus_data driven", bus_data, loc_rdata);
            if (loc_rd_stb) n_rd++;
            if (loc_wr_stb) n_wr++;
            if (err_conflict) n_err++;
        end
    end

    task automatic clear_counts();
        n_rd = 0; n_wr = 0; n_err = 0;
    endtask

    task automatic go_idle(input int n);
        cs_n = 1; oe_n = 1; we_n = 1; drv = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input int n);
        cs_n = 0; oe_n = 0; we_n = 1; drv = 0; addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input int n);
        cs_n = 0; oe_n = 1; we_n = 0; drv = 1; dat = d; addr = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check(!loc_rd_stb && !loc_wr_stb && !err_conflict, "R1 reset strobes", {loc_rd_stb, loc_wr_stb, err_conflict}, 0);
        check(!dbg_cs_act && !dbg_addr_stable, "R1 reset debug", {dbg_cs_act, dbg_addr_stable}, 0);
        check(loc_addr == '0, "R2 reset loc_addr", 32'(loc_addr), 0);
        @(negedge clk);
        rst_n = 1;
        go_idle(3);

        // Plain read, with synchroniser latency on the select.
        clear_counts();
        cs_n = 0; oe_n = 0; we_n = 1; addr = 9'h012;
        #1 check(dbg_cs_act == 1'b0, "R8 latency edge0", 32'(dbg_cs_act), 0);
        @(negedge clk); #1 check(dbg_cs_act == 1'b0, "R8 latency edge1", 32'(dbg_cs_act), 0);
        @(negedge clk); #1 check(dbg_cs_act == 1'b1, "R8 latency edge2", 32'(dbg_cs_act), 1);
        repeat (4) @(negedge clk);
        go_idle(4);
        check(n_rd == 1 && n_wr == 0, "R4 one read strobe", n_rd, 1);
        check(loc_addr == 9'h012, "R2 read address", 32'(loc_addr), 32'h012);

        // Plain write.
        clear_counts();
        do_write(9'h1AB, 32'hDEAD_BEEF, 6);
        go_idle(4);
        check(n_wr == 1 && n_rd == 0, "R4 one write strobe", n_wr, 1);
        check(loc_wdata == 32'hDEAD_BEEF, "R10 write data", loc_wdata, 32'hDEAD_BEEF);

        // Select held across two addresses.
        clear_counts();
        do_read(9'h040, 6);
        do_read(9'h041, 6);
        go_idle(4);
        check(n_rd == 2, "R5 two reads under one select", n_rd, 2);
        check(loc_addr == 9'h041, "R5 second address", 32'(loc_addr), 32'h041);

        // Both enables low: write wins and the conflict is flagged.
        clear_counts();
        cs_n = 0; oe_n = 0; we_n = 0; drv = 0; addr = 9'h0F0;
        repeat (6) @(negedge clk);
        go_idle(4);
        check(n_wr == 1, "R6 write wins", n_wr, 1);
        check(n_rd == 0, "R6 no read", n_rd, 0);
        check(n_err == 1, "R6 conflict flagged", n_err, 1);

        // Select inactive with enables low: no access, bus not driven.
        clear_counts();
        cs_n = 1; oe_n = 0; we_n = 1; addr = 9'h0AA; drv = 1; dat = 32'h0;
        repeat (8) @(negedge clk);
        #1 check(bus_data == 32'h0, "R7 bus released", bus_data, 0);
        check(!dbg_addr_stable && !dbg_rd_ok, "R1 no qualification", {dbg_addr_stable, dbg_rd_ok}, 0);
        go_idle(3);
        check(n_rd == 0 && n_wr == 0, "R1 no strobe", n_rd + n_wr, 0);

        // Stability boundary: 2 edges is too short, 3 edges qualifies.
        clear_counts();
        do_read(9'h155, 2);
        go_idle(5);
        check(n_rd == 0, "R3 two edges rejected", n_rd, 0);
        clear_counts();
        do_read(9'h0C3, 3);
        go_idle(5);
        check(n_rd == 1, "R3 three edges accepted", n_rd, 1);

        // Long window still yields a single strobe.
        clear_counts();
        do_read(9'h077, 20);
        go_idle(4);
        check(n_rd == 1, "R4 long window single strobe", n_rd, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule